// File: doc/BRIEF.md
# Run-Length Transition Density Monitor

This block sits on a parallel receive data path and tracks how long the recovered serial stream has gone without a bit transition. Each clock that carries a valid word, it walks the word's bits in serial order, least significant bit first. It continues the run from the last bit of the previous word, so a run that crosses a word boundary is counted as one run. The width of the word is selectable among 8, 10, 16 and 20 bits. Bits above the selected width are ignored.

The trip point is computed from a programmed threshold, a selectable scale factor and the selected width. The effective threshold is the threshold times the scale, plus half the word width. A registered alarm output tells user logic that a run at least that long has been seen. The current run count is also exposed as a registered output. The block only watches the data and never alters it.

Top module: `run_len_mon`

## Requirements
- R1: The effective threshold is `thresh * scale + width/2`. `scale_sel` 0,1,2,3 selects a scale of 1, 4, 16 or 64. A run count equal to the effective threshold is enough to trip the alarm.
- R2: `width_sel` 0,1,2,3 selects a word width of 8, 10, 16 or 20 bits, taken from the low end of `rx_word`. Bits at or above the selected width have no effect on the count or the alarm.
- R3: Bits are taken in serial order, bit 0 first. The last evaluated bit of each word is kept, and the first bit of the next word is compared against it.
- R4: The run count is advanced once per evaluated bit position. It grows by one when the bit equals the bit before it, and it becomes 0 when the bit differs. So after the word is taken, the count equals the number of positions since the last transition. The count is visible on `run_count` one clock after the word is presented.
- R5: `alarm` is registered. It is high for a word when any evaluated bit position of that word brings the count to at least the effective threshold. A long run that ends inside a word therefore still raises the alarm. The alarm is low after any word in which no position reaches the threshold. As a result, it drops on the clock after the word that ends a long run with a transition and leaves a short run behind.
- R6: The run count saturates at 2^CW-1 and does not wrap.
- R7: When `rx_valid` is low, the count, the kept last bit and the alarm are all held.
- R8: Synchronous active-high `rst` clears the run count, the kept last bit (to 0) and the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | DW (20) | Parallel receive word, bit 0 is first in serial order |
| rx_valid | input | 1 | Word strobe |
| thresh | input | TW (8) | Programmed run threshold |
| scale_sel | input | 2 | Scale factor select: 1, 4, 16, 64 |
| width_sel | input | 2 | Word width select: 8, 10, 16, 20 |
| run_count | output | CW (16) | Current run count |
| alarm | output | 1 | Run-length alarm |

## Verification
The main function is driven with several kinds of words:
- All-constant words in succession show that the count accumulates across word boundaries.
- A word whose first bit differs from the kept bit shows that the boundary transition is detected.
- Alternating patterns show that the count resets at every position.
- A long run ending mid-word shows that the alarm reports a run that has already finished.
- Junk placed above the selected width in every width mode shows that only the chosen lanes matter.

Pairs of thresholds one apart, around a known count, pin down the at-or-above comparison and each scale factor. A long stream of constant words drives the counter into saturation.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  localparam int unsigned LEN_W = 6;

  function automatic logic [LEN_W-1:0] lane_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    lane_bits = 6'd8;
      2'd1:    lane_bits = 6'd10;
      2'd2:    lane_bits = 6'd16;
      default: lane_bits = 6'd20;
    endcase
  endfunction

  function automatic logic [2:0] scale_shift(input logic [1:0] sel);
    scale_shift = {sel, 1'b0};
  endfunction

endpackage

// File: rtl/rlm_thresh_calc.sv
module rlm_thresh_calc #(
  parameter int unsigned TW = 8,
  parameter int unsigned EW = TW + 7
) (
  input  logic [TW-1:0] thresh,
  input  logic [1:0]    scale_sel,
  input  logic [1:0]    width_sel,
  output logic [EW-1:0] eff_thresh
);
  import rlm_pkg::*;

  logic [EW-1:0] scaled;
  logic [EW-1:0] half_w;

  always_comb begin
    scaled     = EW'(thresh) << scale_shift(scale_sel);
    half_w     = EW'(lane_bits(width_sel) >> 1);
    eff_thresh = scaled + half_w;
  end

endmodule

// File: rtl/rlm_run_chain.sv
module rlm_run_chain #(
  parameter int unsigned DW = 20,
  parameter int unsigned CW = 16
) (
  input  logic [DW-1:0] word,
  input  logic [1:0]    width_sel,
  input  logic          prev_bit,
  input  logic [CW-1:0] count_in,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count_out,
  output logic          tail_bit,
  output logic          hit
);
  import rlm_pkg::*;

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [LEN_W-1:0] n_lanes;
  logic [CW-1:0]    cnt_at [DW+1];
  logic             bit_at [DW+1];
  logic [DW-1:0]    hit_at;

  assign n_lanes   = lane_bits(width_sel);
  assign cnt_at[0] = count_in;
  assign bit_at[0] = prev_bit;

  for (genvar gi = 0; gi < DW; gi++) begin : g_pos
    logic          live;
    logic          same;
    logic [CW-1:0] bumped;

    assign live   = LEN_W'(gi) < n_lanes;
    assign same   = word[gi] == bit_at[gi];
    assign bumped = (cnt_at[gi] == CMAX) ? CMAX : cnt_at[gi] + 1'b1;

    assign cnt_at[gi+1] = !live ? cnt_at[gi] : (same ? bumped : '0);
    assign bit_at[gi+1] = live ? word[gi] : bit_at[gi];
    assign hit_at[gi]   = live && (cnt_at[gi+1] >= limit);
  end

  assign count_out = cnt_at[DW];
  assign tail_bit  = bit_at[DW];
  assign hit       = |hit_at;

endmodule

// File: rtl/rlm_state_reg.sv
module rlm_state_reg #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] count_nxt,
  input  logic          bit_nxt,
  input  logic          hit_nxt,
  output logic [CW-1:0] count_q,
  output logic          bit_q,
  output logic          alarm_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      bit_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else if (step) begin
      count_q <= count_nxt;
      bit_q   <= bit_nxt;
      alarm_q <= hit_nxt;
    end
  end

endmodule

// File: rtl/run_len_mon.sv
module run_len_mon #(
  parameter int unsigned DW = 20,
  parameter int unsigned TW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_valid,
  input  logic [TW-1:0] thresh,
  input  logic [1:0]    scale_sel,
  input  logic [1:0]    width_sel,
  output logic [CW-1:0] run_count,
  output logic          alarm
);

  localparam int unsigned EW = TW + 7;

  logic [EW-1:0] eff_thresh;
  logic [CW-1:0] limit;
  logic [CW-1:0] count_nxt;
  logic          bit_nxt;
  logic          hit_nxt;
  logic          last_bit;

  rlm_thresh_calc #(.TW(TW), .EW(EW)) u_thr (
    .thresh     (thresh),
    .scale_sel  (scale_sel),
    .width_sel  (width_sel),
    .eff_thresh (eff_thresh)
  );

  assign limit = CW'(eff_thresh);

  rlm_run_chain #(.DW(DW), .CW(CW)) u_chain (
    .word      (rx_word),
    .width_sel (width_sel),
    .prev_bit  (last_bit),
    .count_in  (run_count),
    .limit     (limit),
    .count_out (count_nxt),
    .tail_bit  (bit_nxt),
    .hit       (hit_nxt)
  );

  rlm_state_reg #(.CW(CW)) u_state (
    .clk       (clk),
    .rst       (rst),
    .step      (rx_valid),
    .count_nxt (count_nxt),
    .bit_nxt   (bit_nxt),
    .hit_nxt   (hit_nxt),
    .count_q   (run_count),
    .bit_q     (last_bit),
    .alarm_q   (alarm)
  );

endmodule

// File: rtl/rlm_checker.sv
module rlm_checker #(
  parameter int unsigned DW = 20,
  parameter int unsigned TW = 8,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic [TW-1:0] thresh,
  input logic [1:0]    scale_sel,
  input logic [1:0]    width_sel,
  input logic [CW-1:0] run_count,
  input logic          alarm
);
  import rlm_pkg::*;

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] trip;
  always_comb begin
    trip = (CW'(thresh) << scale_shift(scale_sel)) + CW'(lane_bits(width_sel) >> 1);
  end

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (run_count == '0 && !alarm));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(run_count) && $stable(alarm)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && run_count == CMAX) |=> (run_count == CMAX || run_count < CW'(DW)));

  a_r4_bounded_growth: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (run_count < CW'(DW) || run_count == CMAX ||
                  run_count <= $past(run_count) + CW'(DW)));

  a_r1_trip_reached: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_valid) && run_count >= $past(trip)) |-> alarm);

endmodule

bind run_len_mon rlm_checker #(.DW(DW), .TW(TW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .thresh    (thresh),
  .scale_sel (scale_sel),
  .width_sel (width_sel),
  .run_count (run_count),
  .alarm     (alarm)
);

// File: tb/sim_run_len_mon.sv
module sim_run_len_mon;

  localparam int unsigned CLK_P = 10;
  localparam int unsigned DW = 20;
  localparam int unsigned TW = 8;
  localparam int unsigned CW = 16;
  localparam int unsigned NVEC = 15;

  typedef struct packed {
    logic [1:0]  wsel;
    logic [1:0]  ssel;
    logic [7:0]  thr;
    logic [19:0] data;
    logic [15:0] cnt;
    logic        al;
  } vec_t;

  // walked in order from reset; state carries over between rows (R2 R3 R4 R5 R1)
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd0, 8'd10, 20'h00000, 16'd8,  1'b0},
    '{2'd0, 2'd0, 8'd10, 20'h00000, 16'd16, 1'b1},
    '{2'd0, 2'd0, 8'd10, 20'h00001, 16'd6,  1'b0},
    '{2'd0, 2'd0, 8'd10, 20'h000FF, 16'd7,  1'b0},
    '{2'd0, 2'd0, 8'd10, 20'h000FF, 16'd15, 1'b1},
    '{2'd0, 2'd0, 8'd10, 20'h000FF, 16'd23, 1'b1},
    '{2'd0, 2'd0, 8'd10, 20'h0007F, 16'd0,  1'b1},
    '{2'd0, 2'd0, 8'd10, 20'hFFF00, 16'd8,  1'b0},
    '{2'd1, 2'd1, 8'd2,  20'hFFC00, 16'd18, 1'b1},
    '{2'd2, 2'd0, 8'd0,  20'hFAAAA, 16'd0,  1'b1},
    '{2'd2, 2'd0, 8'd0,  20'h0FFFF, 16'd16, 1'b1},
    '{2'd3, 2'd2, 8'd1,  20'h00000, 16'd19, 1'b0},
    '{2'd3, 2'd2, 8'd1,  20'h00001, 16'd18, 1'b0},
    '{2'd3, 2'd2, 8'd1,  20'h00000, 16'd38, 1'b1},
    '{2'd3, 2'd3, 8'd1,  20'h00000, 16'd58, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] rx_word = '0;
  logic          rx_valid = 1'b0;
  logic [TW-1:0] thresh = '0;
  logic [1:0]    scale_sel = '0;
  logic [1:0]    width_sel = '0;
  logic [CW-1:0] run_count;
  logic          alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  run_len_mon #(.DW(DW), .TW(TW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_valid(rx_valid),
    .thresh(thresh), .scale_sel(scale_sel), .width_sel(width_sel),
    .run_count(run_count), .alarm(alarm)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step(input logic r, input logic v, input logic [1:0] ws,
                      input logic [1:0] ss, input logic [7:0] th, input logic [19:0] d);
    @(negedge clk);
    rst = r; rx_valid = v; width_sel = ws; scale_sel = ss; thresh = th; rx_word = d;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic check(input string req, input logic [15:0] ec, input logic ea);
    n_chk++;
    if (run_count !== ec || alarm !== ea) begin
      n_bad++;
      $display("FAIL %s: count=%0d alarm=%0b expected count=%0d alarm=%0b",
               req, run_count, alarm, ec, ea);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    step(1'b1, 1'b0, 2'd0, 2'd0, 8'd10, 20'h0);
    step(1'b1, 1'b0, 2'd0, 2'd0, 8'd10, 20'h0);
    check("R8 reset state", 16'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, 1'b1, VEC[i].wsel, VEC[i].ssel, VEC[i].thr, VEC[i].data);
      check($sformatf("R4/R5 vector %0d", i), VEC[i].cnt, VEC[i].al);
    end

    // R1 boundary: eff = 4*1 + 4 = 8, count 8 trips
    step(1'b1, 1'b0, 2'd0, 2'd0, 8'd4, 20'h0);
    step(1'b0, 1'b1, 2'd0, 2'd0, 8'd4, 20'h0);
    check("R1 count equal to threshold trips", 16'd8, 1'b1);
    // R1 boundary: eff = 5 + 4 = 9, count 8 does not
    step(1'b1, 1'b0, 2'd0, 2'd0, 8'd5, 20'h0);
    step(1'b0, 1'b1, 2'd0, 2'd0, 8'd5, 20'h0);
    check("R1 count one below threshold", 16'd8, 1'b0);

    // R7: invalid words (with a transition pattern) are ignored
    step(1'b0, 1'b0, 2'd0, 2'd0, 8'd5, 20'h00001);
    step(1'b0, 1'b0, 2'd0, 2'd0, 8'd5, 20'h000FF);
    check("R7 hold while invalid", 16'd8, 1'b0);
    step(1'b0, 1'b1, 2'd0, 2'd0, 8'd5, 20'h00000);
    check("R7 last bit kept while invalid", 16'd16, 1'b1);

    // R8: mid-run reset clears kept last bit (would give 7 if it stayed 1)
    step(1'b0, 1'b1, 2'd0, 2'd0, 8'd10, 20'h000FF);
    step(1'b1, 1'b1, 2'd0, 2'd0, 8'd10, 20'hFFFFF);
    check("R8 reset mid run", 16'd0, 1'b0);
    step(1'b0, 1'b1, 2'd0, 2'd0, 8'd10, 20'h00000);
    check("R8 last bit cleared by reset", 16'd8, 1'b0);

    // R6: saturation, eff = 255*64 + 10 = 16330
    step(1'b1, 1'b0, 2'd3, 2'd3, 8'd255, 20'h0);
    for (int k = 0; k < 3300; k++) begin
      step(1'b0, 1'b1, 2'd3, 2'd3, 8'd255, 20'h00000);
    end
    check("R6 saturated count", 16'hFFFF, 1'b1);
    step(1'b0, 1'b1, 2'd3, 2'd3, 8'd255, 20'h00000);
    check("R6 no wrap", 16'hFFFF, 1'b1);
    step(1'b0, 1'b1, 2'd3, 2'd3, 8'd255, 20'h00001);
    check("R3/R5 transition after saturation", 16'd18, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule